// File: doc/BRIEF.md
# I2C Master Event Flag Controller

This block keeps the two error flags that an I2C master reports to software: a no-acknowledge flag and an arbitration-lost flag. The bus engine sends it single-cycle strobes: an acknowledge bit seen, a no-acknowledge bit seen, arbitration lost, a start request, and the current bus-busy and general-call levels. The block decides from these strobes when each flag sets. Software clears a flag by writing a one to its bit in the status register. A flag also clears when a CPU read of the interrupt-source register returns that flag's code.

A read that is marked as debug access returns the same data but changes nothing, so a debugger can look at the source register without losing pending events. When arbitration is lost, the block issues a one-cycle pulse. The control register uses this pulse to drop its master-mode and stop-request bits, so the module falls back to slave-receiver operation. An interrupt request is raised for each pending flag whose enable input is high.

Top module: `i2c_evt_flags`

## Requirements
- R1: After `rst_n` is released, `flag_nack`, `flag_arbl`, `irq` and `mst_clr` are 0 and `int_src` is 0. A cycle with `mod_rst` high clears both flags and `mst_clr` at the next edge.
- R2: A `bus_nack` strobe sets `flag_nack` at the next edge. A `bus_ack` strobe while `gen_call` is 0 clears it at the next edge.
- R3: While `gen_call` is 1, a `bus_ack` strobe sets `flag_nack` instead of clearing it.
- R4: `flag_arbl` sets at the next edge on a `bus_arb_lost` strobe, or on `start_req` while `bus_busy` is 1. A `start_req` while `bus_busy` is 0 leaves it at 0.
- R5: `mst_clr` is high for exactly one cycle, in the same cycle in which `flag_arbl` first reads 1. It does not pulse again while the set condition stays high and the flag is already 1.
- R6: A write (`cpu_wr`) with `cpu_addr`=0 (status register) clears `flag_nack` when `cpu_wdata` bit 1 is 1 and clears `flag_arbl` when bit 0 is 1. Zero bits have no effect.
- R7: A non-debug read (`cpu_rd`, `cpu_dbg`=0) with `cpu_addr`=1 (source register) clears only the flag whose code it returns. A read of the status register changes no flag.
- R8: A source-register read with `cpu_dbg`=1 leaves both flags unchanged. Two such reads in a row return the same code.
- R9: `int_src` is 0 with no flag pending, 1 when `flag_arbl` is set, and 2 when only `flag_nack` is set. Arbitration-lost has priority. A source-register read returns `int_src` on `cpu_rdata`. A status-register read returns `flag_arbl` on bit 0 and `flag_nack` on bit 1.
- R10: `irq` is high exactly when (`flag_nack` and `ien_nack`) or (`flag_arbl` and `ien_arbl`).
- R11: When a set event and a clear (write-1 or source read) reach the same flag in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| mod_rst | input | 1 | Synchronous module reset, active high |
| bus_ack | input | 1 | Acknowledge bit seen (strobe) |
| bus_nack | input | 1 | No-acknowledge bit seen (strobe) |
| bus_arb_lost | input | 1 | Arbitration lost to another transmitter (strobe) |
| start_req | input | 1 | Start requested (strobe) |
| bus_busy | input | 1 | Bus-busy level |
| gen_call | input | 1 | General-call transfer in progress |
| ien_nack | input | 1 | Interrupt enable for the no-acknowledge flag |
| ien_arbl | input | 1 | Interrupt enable for the arbitration-lost flag |
| cpu_addr | input | 1 | 0 selects the status register, 1 the source register |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_dbg | input | 1 | Marks the access as a debug access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, combinational from registered state |
| flag_nack | output | 1 | No-acknowledge flag |
| flag_arbl | output | 1 | Arbitration-lost flag |
| int_src | output | SRC_W | Interrupt-source code |
| irq | output | 1 | Interrupt request |
| mst_clr | output | 1 | One-cycle pulse that drops master mode |

## Verification
The properties assume that `bus_ack` and `bus_nack` never arrive in the same cycle and that one CPU access is in flight per cycle. The debug-hold property also assumes that no acknowledge strobe arrives during the debug read. The stimulus table and the directed tests keep to these rules. A same-cycle set and clear is driven only through the CPU port, where R11 defines the result. Strobes are driven for one cycle at a time, except in the held-arbitration test, which checks that the pulse is not repeated.

// File: rtl/i2c_evt_flags_pkg.sv
package i2c_evt_flags_pkg;
   localparam int FLAG_NUM = 2;
   // index order is also the source-code priority: lower index wins
   localparam int IDX_ARBL = 0;
   localparam int IDX_NACK = 1;
   localparam int CODE_NONE = 0;
   localparam int CODE_ARBL = IDX_ARBL + 1;
   localparam int CODE_NACK = IDX_NACK + 1;

   typedef enum logic {
      REG_STAT = 1'b0,
      REG_SRC  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/evf_flag_cell.sv
module evf_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mod_rst,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o,
   output logic rise_o
);
   logic flag_q;
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb flag_d = set_i | (flag_q & ~clr_i);
      end else begin : g_clr_first
         always_comb flag_d = ~clr_i & (set_i | flag_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (mod_rst) flag_q <= 1'b0;
      else              flag_q <= flag_d;
   end

   assign flag_o = flag_q;
   assign rise_o = flag_d & ~flag_q & ~mod_rst;
endmodule

// File: rtl/evf_src_enc.sv
module evf_src_enc #(
   parameter int N     = 2,
   parameter int SRC_W = 3
) (
   input  logic [N-1:0]     flags_i,
   output logic [SRC_W-1:0] code_o,
   output logic [N-1:0]     sel_o
);
   if (N < 1) begin : g_bad_n
      $error("evf_src_enc: N must be at least 1");
   end
   if ((1 << SRC_W) <= N) begin : g_bad_w
      $error("evf_src_enc: SRC_W too narrow for N codes");
   end

   always_comb begin
      code_o = '0;
      sel_o  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (flags_i[i]) begin
            code_o   = SRC_W'(i + 1);
            sel_o    = '0;
            sel_o[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/evf_cpu_port.sv
module evf_cpu_port
   import i2c_evt_flags_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SRC_W    = 3,
   parameter int ARBL_BIT = 0,
   parameter int NACK_BIT = 1
) (
   input  logic                cpu_addr,
   input  logic                cpu_rd,
   input  logic                cpu_wr,
   input  logic                cpu_dbg,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic [FLAG_NUM-1:0] flags_i,
   input  logic [FLAG_NUM-1:0] sel_i,
   input  logic [SRC_W-1:0]    code_i,
   output logic [FLAG_NUM-1:0] clr_o,
   output logic [DATA_W-1:0]   rdata_o
);
   if (ARBL_BIT == NACK_BIT) begin : g_bad_pos
      $error("evf_cpu_port: flag bit positions must differ");
   end
   if (ARBL_BIT >= DATA_W || NACK_BIT >= DATA_W) begin : g_bad_range
      $error("evf_cpu_port: flag bit outside data word");
   end
   if (SRC_W > DATA_W) begin : g_bad_src
      $error("evf_cpu_port: source code wider than data word");
   end

   function automatic int bit_of(input int idx);
      return (idx == IDX_ARBL) ? ARBL_BIT : NACK_BIT;
   endfunction

   logic wr_stat;
   logic rd_src;
   assign wr_stat = cpu_wr & (reg_sel_e'(cpu_addr) == REG_STAT);
   assign rd_src  = cpu_rd & ~cpu_dbg & (reg_sel_e'(cpu_addr) == REG_SRC);

   logic [DATA_W-1:0] stat_word;

   for (genvar g = 0; g < FLAG_NUM; g++) begin : g_flag
      assign clr_o[g] = (wr_stat & cpu_wdata[bit_of(g)]) | (rd_src & sel_i[g]);
   end

   always_comb begin
      stat_word = '0;
      for (int i = 0; i < FLAG_NUM; i++) stat_word[bit_of(i)] = flags_i[i];
   end

   assign rdata_o = (reg_sel_e'(cpu_addr) == REG_SRC) ? DATA_W'(code_i) : stat_word;
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
   import i2c_evt_flags_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SRC_W    = 3,
   parameter int ARBL_BIT = 0,
   parameter int NACK_BIT = 1,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_rst,
   input  logic              bus_ack,
   input  logic              bus_nack,
   input  logic              bus_arb_lost,
   input  logic              start_req,
   input  logic              bus_busy,
   input  logic              gen_call,
   input  logic              ien_nack,
   input  logic              ien_arbl,
   input  logic              cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic              cpu_dbg,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              flag_nack,
   output logic              flag_arbl,
   output logic [SRC_W-1:0]  int_src,
   output logic              irq,
   output logic              mst_clr
);
   if (!SET_WINS) begin : g_bad_policy
      $error("i2c_evt_flags: set events must win over clears");
   end

   logic [FLAG_NUM-1:0] set_v, clr_bus, clr_cpu, flags, rise, sel, ien;
   logic                mst_clr_q;

   // set and bus-side clear sources
   always_comb begin
      set_v           = '0;
      clr_bus         = '0;
      set_v[IDX_ARBL] = bus_arb_lost | (start_req & bus_busy);
      set_v[IDX_NACK] = bus_nack | (bus_ack & gen_call);
      clr_bus[IDX_NACK] = bus_ack & ~gen_call;
   end

   assign ien[IDX_ARBL] = ien_arbl;
   assign ien[IDX_NACK] = ien_nack;

   for (genvar g = 0; g < FLAG_NUM; g++) begin : g_cell
      evf_flag_cell #(.SET_WINS(SET_WINS)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .mod_rst(mod_rst),
         .set_i  (set_v[g]),
         .clr_i  (clr_bus[g] | clr_cpu[g]),
         .flag_o (flags[g]),
         .rise_o (rise[g])
      );
   end

   evf_src_enc #(.N(FLAG_NUM), .SRC_W(SRC_W)) u_enc (
      .flags_i(flags),
      .code_o (int_src),
      .sel_o  (sel)
   );

   evf_cpu_port #(
      .DATA_W  (DATA_W),
      .SRC_W   (SRC_W),
      .ARBL_BIT(ARBL_BIT),
      .NACK_BIT(NACK_BIT)
   ) u_cpu (
      .cpu_addr (cpu_addr),
      .cpu_rd   (cpu_rd),
      .cpu_wr   (cpu_wr),
      .cpu_dbg  (cpu_dbg),
      .cpu_wdata(cpu_wdata),
      .flags_i  (flags),
      .sel_i    (sel),
      .code_i   (int_src),
      .clr_o    (clr_cpu),
      .rdata_o  (cpu_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mst_clr_q <= 1'b0;
      else        mst_clr_q <= rise[IDX_ARBL];
   end

   assign flag_nack = flags[IDX_NACK];
   assign flag_arbl = flags[IDX_ARBL];
   assign irq       = |(flags & ien);
   assign mst_clr   = mst_clr_q;
endmodule

// File: rtl/i2c_evt_flags_chk.sv
module i2c_evt_flags_chk #(
   parameter int SRC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mod_rst,
   input logic             bus_ack,
   input logic             bus_nack,
   input logic             bus_arb_lost,
   input logic             start_req,
   input logic             bus_busy,
   input logic             cpu_rd,
   input logic             cpu_wr,
   input logic             cpu_dbg,
   input logic             flag_nack,
   input logic             flag_arbl,
   input logic [SRC_W-1:0] int_src,
   input logic             irq,
   input logic             mst_clr
);
   // R1
   mod_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_rst |=> (!flag_nack && !flag_arbl && !mst_clr));
   // R2
   nack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_nack && !mod_rst) |=> flag_nack);
   // R4
   arbl_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_arb_lost || (start_req && bus_busy)) && !mod_rst) |=> flag_arbl);
   // R5
   mst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mst_clr |=> !mst_clr);
   // R5
   mst_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_arbl) |-> mst_clr);
   // R8
   dbg_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_dbg && !cpu_wr && !mod_rst && !bus_ack && flag_nack) |=> flag_nack);
   // R9
   arbl_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_arbl |-> (int_src == SRC_W'(1)));
   // R10
   no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_nack && !flag_arbl) |-> !irq);
endmodule

bind i2c_evt_flags i2c_evt_flags_chk #(.SRC_W(SRC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mod_rst(mod_rst), .bus_ack(bus_ack),
   .bus_nack(bus_nack), .bus_arb_lost(bus_arb_lost), .start_req(start_req),
   .bus_busy(bus_busy), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_dbg(cpu_dbg),
   .flag_nack(flag_nack), .flag_arbl(flag_arbl), .int_src(int_src),
   .irq(irq), .mst_clr(mst_clr)
);

// File: tb/test_i2c_evt_flags.sv
module test_i2c_evt_flags;
   localparam int DATA_W = 8;
   localparam int SRC_W  = 3;

   logic clk = 1'b0, rst_n = 1'b0, mod_rst = 1'b0;
   logic bus_ack = 0, bus_nack = 0, bus_arb_lost = 0, start_req = 0, bus_busy = 0, gen_call = 0;
   logic ien_nack = 0, ien_arbl = 0, cpu_addr = 0, cpu_rd = 0, cpu_wr = 0, cpu_dbg = 0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic flag_nack, flag_arbl, irq, mst_clr;
   logic [SRC_W-1:0] int_src;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   i2c_evt_flags #(.DATA_W(DATA_W), .SRC_W(SRC_W)) i_i2c_evt_flags (.*);

   task automatic check(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic idle();
      {bus_ack, bus_nack, bus_arb_lost, start_req, bus_busy, gen_call} = '0;
      {cpu_rd, cpu_wr, cpu_dbg, cpu_addr} = '0;
      cpu_wdata = '0;
      mod_rst = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // [15]ack [14]nack [13]arb [12]start [11]busy [10]gencall [9]rd [8]wr [7]dbg
   // [6]addr [5:4]wdata{nack,arbl} [3]exp nack [2]exp arbl [1:0]exp code
   localparam int NV = 17;
   localparam logic [15:0] VEC [NV] = '{
      16'b0_1_0_0_0_0_0_0_0_0_00_1_0_10, // R2 nack sets
      16'b1_0_0_0_0_0_0_0_0_0_00_0_0_00, // R2 ack clears
      16'b1_0_0_0_0_1_0_0_0_0_00_1_0_10, // R3 ack in general call
      16'b0_0_0_0_0_0_0_1_0_0_00_1_0_10, // R6 write zeros
      16'b0_0_0_0_0_0_0_1_0_0_10_0_0_00, // R6 write-1 nack
      16'b0_0_1_0_0_0_0_0_0_0_00_0_1_01, // R4 arbitration lost
      16'b0_1_0_0_0_0_0_0_0_0_00_1_1_01, // R9 both, arbl priority
      16'b0_0_0_0_0_0_1_0_1_1_00_1_1_01, // R8 debug read
      16'b0_0_0_0_0_0_1_0_0_1_00_1_0_10, // R7 source read clears arbl only
      16'b0_0_0_0_0_0_1_0_0_1_00_0_0_00, // R7 source read clears nack
      16'b0_0_0_1_1_0_0_0_0_0_00_0_1_01, // R4 start while busy
      16'b0_0_0_0_0_0_0_1_0_0_01_0_0_00, // R6 write-1 arbl
      16'b0_0_0_1_0_0_0_0_0_0_00_0_0_00, // R4 start while idle
      16'b0_1_0_0_0_0_0_1_0_0_10_1_0_10, // R11 set beats write clear
      16'b0_0_0_0_0_0_1_0_0_0_00_1_0_10, // R7 status read no effect
      16'b0_1_0_0_0_0_1_0_0_1_00_1_0_10, // R11 set beats read clear
      16'b0_0_0_0_0_0_0_1_0_0_10_0_0_00  // R6 cleanup
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 nack", flag_nack, 0);
      check("R1 arbl", flag_arbl, 0);
      check("R1 code", int_src, 0);
      check("R1 irq", irq, 0);
      check("R1 mst_clr", mst_clr, 0);

      for (int v = 0; v < NV; v++) begin
         {bus_ack, bus_nack, bus_arb_lost, start_req, bus_busy, gen_call,
          cpu_rd, cpu_wr, cpu_dbg, cpu_addr} = VEC[v][15:6];
         cpu_wdata = {6'b0, VEC[v][5:4]};
         tick();
         idle();
         check($sformatf("R2-vec%0d nack", v), flag_nack, VEC[v][3]);
         check($sformatf("R4-vec%0d arbl", v), flag_arbl, VEC[v][2]);
         check($sformatf("R9-vec%0d code", v), int_src, VEC[v][1:0]);
      end

      // R5 pulse with held arbitration loss
      bus_arb_lost = 1;
      tick();
      check("R5 pulse high", mst_clr, 1);
      check("R5 flag", flag_arbl, 1);
      tick();
      check("R5 pulse one cycle", mst_clr, 0);
      tick();
      check("R5 no repeat", mst_clr, 0);
      idle();

      // R10 enables
      check("R10 disabled", irq, 0);
      ien_arbl = 1;
      #1 check("R10 arbl enabled", irq, 1);
      ien_arbl = 0; ien_nack = 1;
      #1 check("R10 nack enabled no nack", irq, 0);
      bus_nack = 1;
      tick();
      idle();
      check("R10 nack enabled", irq, 1);

      // R8 debug reads twice, R9 read data
      cpu_rd = 1; cpu_dbg = 1; cpu_addr = 1;
      #1 c1 = cpu_rdata;
      check("R9 src rdata", c1, 1);
      tick();
      check("R8 second debug read", cpu_rdata, c1);
      tick();
      check("R8 arbl kept", flag_arbl, 1);
      idle();
      cpu_rd = 1; cpu_addr = 0;
      #1 check("R9 status rdata", cpu_rdata, 3);
      idle();

      // R1 module reset
      mod_rst = 1;
      tick();
      idle();
      check("R1 mod_rst nack", flag_nack, 0);
      check("R1 mod_rst arbl", flag_arbl, 0);
      check("R1 mod_rst irq", irq, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule